// File: doc/BRIEF.md
# Byte-Lane Static RAM Bus Model

This block is a synthesizable, clock-sampled model of a 16-bit-wide asynchronous static RAM. It is meant to sit in a simulation or emulation environment as the target of a memory controller. The inputs are the usual asynchronous-SRAM pins: an address, a pair of chip enables of opposite polarity, active-low output and write strobes, and an active-low select for each byte lane. A fast model clock samples these strobes. The clock rate is chosen well above the controller's strobe rate.

A write is the overlap of all the write qualifiers. It is committed on the first model clock edge at which that overlap is seen to have ended. The address, data and lane mask used are the ones sampled at the last edge of the overlap, so data may change together with the terminating strobe.

Reads are combinational from the current address and strobes. The controller's own wait states provide the access time. Two outputs replace the tri-state pins: a per-lane drive-enable vector, and a read bus that is zero on every lane not being driven.

The stored depth is a parameter, so simulation stays small. The full address is folded onto the index: index bit k is the XOR of every address bit i with i mod IDX_W equal to k, where IDX_W = log2(DEPTH). When DEPTH is the full 2^ADDR_W this is the identity map. Memory contents are never reset.

Top module: `sram_bus_model`

## Requirements
- R1: Each stored word is reached through the folded index of the address (index bit k = XOR of all address bits i with i mod log2(DEPTH) = k). Any two addresses with the same fold alias the same word, and every index holds its own 16-bit value.
- R2: With chipEnN high or chipEn low, laneOe is 2'b00 and rdData is zero, whatever the other inputs are. A write strobe held in this state changes no stored word.
- R3: With both upperSelN and lowerSelN high, the part is deselected. laneOe is 2'b00 and a write strobe changes no stored word.
- R4: When selected with wrEnN high and outEnN high, laneOe is 2'b00 and rdData is zero.
- R5: A read needs the part selected, wrEnN high and outEnN low. laneOe[0] (rdData[7:0]) is then set exactly when lowerSelN is low, and laneOe[1] (rdData[15:8]) exactly when upperSelN is low. Driven lanes show the stored byte in the same cycle. Undriven lanes read zero.
- R6: While wrEnN is low and both chip enables are active, laneOe is 2'b00 for either value of outEnN. A write commits the same way with outEnN high or low.
- R7: A write is committed at the first clock edge at which the overlap is inactive. It uses the address, data and lane selects sampled at the last edge where the overlap was active. Until that commit edge the stored word keeps its old value.
- R8: A write updates only the lanes whose select was low at the last overlap edge. The other lane keeps its stored byte.
- R9: Any one qualifier ending the overlap terminates the write: wrEnN rising, chipEnN rising, chipEn falling, or both selects going high.
- R10: rst_n low clears a write in progress so it never commits. It leaves the stored words as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model sampling clock |
| rst_n | input | 1 | Active-low reset of the control state only |
| addr | input | 17 | Word address |
| chipEnN | input | 1 | Active-low chip enable |
| chipEn | input | 1 | Active-high chip enable |
| outEnN | input | 1 | Active-low output enable |
| wrEnN | input | 1 | Active-low write strobe |
| upperSelN | input | 1 | Active-low select for bits 15:8 |
| lowerSelN | input | 1 | Active-low select for bits 7:0 |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, zero on undriven lanes |
| laneOe | output | 2 | Drive enable per lane, bit 0 lower, bit 1 upper |

## Verification
A stale overlap flag shows up at the ports on the very next read. Either a write lands one commit too many, or a word keeps its old value after the terminating strobe. Both are visible in the cycle right after the end of the overlap.

A wrong captured lane mask or captured data shows only when that word is read back. For that reason every index is written and then read, and partial-lane writes are checked against the untouched byte.

Drive-enable decoding errors show in the same cycle as the strobe change, because reads are combinational.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // strobes handed from control to datapath each model clock
  typedef struct packed {
    logic             commit;
    logic [LANES-1:0] laneWrite;
    logic [LANES-1:0] laneRead;
  } strobe_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipEnN,
  input  logic              chipEn,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobe,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrWord
);

  logic             chipActive;
  logic             anyLane;
  logic             selected;
  logic             overlapNow;
  logic             overlapQ;
  logic [LANES-1:0] capMask;

  // fold every address bit onto the index
  always_comb begin
    rdIdx = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      rdIdx[i % IDX_W] = rdIdx[i % IDX_W] ^ addr[i];
    end
  end

  assign chipActive = ~chipEnN & chipEn;
  assign anyLane    = |(~laneSelN);
  assign selected   = chipActive & anyLane;
  assign overlapNow = selected & ~wrEnN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overlapQ <= 1'b0;
      capMask  <= '0;
      wrIdx    <= '0;
      wrWord   <= '0;
    end else begin
      overlapQ <= overlapNow;
      if (overlapNow) begin
        capMask <= ~laneSelN;
        wrIdx   <= rdIdx;
        wrWord  <= wrData;
      end
    end
  end

  always_comb begin
    strobe.commit    = overlapQ & ~overlapNow;
    strobe.laneWrite = capMask;
    for (int l = 0; l < LANES; l++) begin
      strobe.laneRead[l] = chipActive & wrEnN & ~outEnN & ~laneSelN[l];
    end
  end

  // R7: a commit is a single-cycle event
  assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> !strobe.commit);

  // R8: a committed write always carries at least one lane
  assert_commit_has_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |-> (strobe.laneWrite != '0));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_model_pkg::*;
#(
  parameter int DEPTH  = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrWord,
  output logic [DATA_W-1:0] rdData
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    // contents deliberately carry no reset
    always_ff @(posedge clk) begin
      if (strobe.commit && strobe.laneWrite[g]) begin
        laneMem[wrIdx] <= wrWord[g*LANE_W +: LANE_W];
      end
    end

    assign rdData[g*LANE_W +: LANE_W] = strobe.laneRead[g] ? laneMem[rdIdx] : '0;
  end

endmodule

// File: rtl/sram_bus_model.sv
module sram_bus_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipEnN,
  input  logic              chipEn,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic              upperSelN,
  input  logic              lowerSelN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LANES-1:0]  laneOe
);

  localparam int IDX_W = $clog2(DEPTH);

  strobe_t           strobe;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] wrWord;

  sram_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .chipEnN  (chipEnN),
    .chipEn   (chipEn),
    .outEnN   (outEnN),
    .wrEnN    (wrEnN),
    .laneSelN ({upperSelN, lowerSelN}),
    .wrData   (wrData),
    .strobe   (strobe),
    .rdIdx    (rdIdx),
    .wrIdx    (wrIdx),
    .wrWord   (wrWord)
  );

  sram_datapath #(.DEPTH(DEPTH)) u_data (
    .clk    (clk),
    .strobe (strobe),
    .rdIdx  (rdIdx),
    .wrIdx  (wrIdx),
    .wrWord (wrWord),
    .rdData (rdData)
  );

  assign laneOe = strobe.laneRead;

  // R2: a deselected part drives nothing
  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chipEnN || !chipEn) |-> (laneOe == '0 && rdData == '0));

  // R6: write strobe wins over output enable
  assert_write_hides_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEnN && !chipEnN && chipEn) |-> (laneOe == '0));

  // R5: an undriven lane reads zero
  assert_undriven_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !laneOe[0] |-> (rdData[7:0] == 8'h00));

endmodule

// File: tb/sram_bus_model_bench.sv
module sram_bus_model_bench;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] addr;
  logic        chipEnN, chipEn, outEnN, wrEnN, upperSelN, lowerSelN;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic [1:0]  laneOe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [15:0] expMem [DEPTH];
  bit          known  [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  sram_bus_model #(.ADDR_W(17), .DEPTH(DEPTH)) u_sram_bus_model (
    .clk(clk), .rst_n(rst_n), .addr(addr), .chipEnN(chipEnN), .chipEn(chipEn),
    .outEnN(outEnN), .wrEnN(wrEnN), .upperSelN(upperSelN), .lowerSelN(lowerSelN),
    .wrData(wrData), .rdData(rdData), .laneOe(laneOe)
  );

  function automatic int foldIdx(logic [16:0] a);
    logic [IDX_W-1:0] r = '0;
    for (int i = 0; i < 17; i++) r[i % IDX_W] = r[i % IDX_W] ^ a[i];
    return int'(r);
  endfunction

  function automatic logic [15:0] laneBits(logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    chipEnN = 1; chipEn = 0; wrEnN = 1; outEnN = 1; upperSelN = 1; lowerSelN = 1;
  endtask

  // term: 0 wrEnN rises, 1 chipEnN rises, 2 chipEn falls, 3 both selects rise
  task automatic doWrite(input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] mask, input int term, input logic oe);
    int idx = foldIdx(a);
    logic [15:0] old = expMem[idx];
    bit wasKnown = known[idx];
    @(negedge clk);
    addr = a; wrData = d; chipEnN = 0; chipEn = 1;
    lowerSelN = ~mask[0]; upperSelN = ~mask[1]; outEnN = oe; wrEnN = 0;
    #1 chk("R6 no drive while writing", 32'(laneOe), 32'd0);
    @(negedge clk);
    wrData = ~d;
    case (term)
      0: begin wrEnN = 1; outEnN = 0; end
      1: chipEnN = 1;
      2: chipEn = 0;
      default: begin upperSelN = 1; lowerSelN = 1; end
    endcase
    if (term == 0 && wasKnown)
      #1 chk("R7 old word before commit edge", 32'(rdData), 32'(old & laneBits(mask)));
    expMem[idx] = (old & ~laneBits(mask)) | (d & laneBits(mask));
    if (mask == 2'b11) known[idx] = 1;
    @(negedge clk);
    if (term == 0 && known[idx])
      #1 chk("R7 new word after commit edge", 32'(rdData), 32'(expMem[idx] & laneBits(mask)));
    idle();
  endtask

  task automatic doRead(input logic [16:0] a, input logic [1:0] mask, input string req);
    int idx = foldIdx(a);
    @(negedge clk);
    addr = a; chipEnN = 0; chipEn = 1; wrEnN = 1; outEnN = 0;
    lowerSelN = ~mask[0]; upperSelN = ~mask[1];
    #1;
    chk(req, 32'(laneOe), 32'(mask));
    chk(req, 32'(rdData), 32'(expMem[idx] & laneBits(mask)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin expMem[i] = '0; known[i] = 0; end
    idle(); addr = '0; wrData = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1 chk("R2 reset state laneOe", 32'(laneOe), 32'd0);
    chk("R2 reset state rdData", 32'(rdData), 32'd0);
    rst_n = 1;

    // R1 R9: fill every index, cycling through every terminating qualifier
    for (int a = 0; a < DEPTH; a++)
      doWrite(17'(a), 16'((a * 16'h9E37) ^ 16'h5A5A), 2'b11, a % 4, a[2]);
    for (int a = 0; a < DEPTH; a++) doRead(17'(a), 2'b11, "R1 R9 full-word readback");
    // R5: single-lane reads
    for (int a = 0; a < DEPTH; a++) doRead(17'(a), (a % 2 == 0) ? 2'b01 : 2'b10, "R5 lane read");

    // R8: partial lane writes keep the other byte
    for (int a = 0; a < DEPTH; a += 3)
      doWrite(17'(a), 16'(a * 16'h0101 + 16'h3C3C), (a % 2 == 0) ? 2'b01 : 2'b10, (a / 3) % 4, 1'b1);
    for (int a = 0; a < DEPTH; a += 3) doRead(17'(a), 2'b11, "R8 partial lanes");

    // R1: alias through upper address bits
    doWrite(17'h1_2345, 16'hBEEF, 2'b11, 0, 1'b0);
    doRead(17'(foldIdx(17'h1_2345)), 2'b11, "R1 alias by fold");

    // R2: write strobe while deselected by either enable
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      addr = 17'd5; wrData = 16'h1234; chipEnN = (v == 0); chipEn = (v != 0) ? 1'b0 : 1'b1;
      upperSelN = 0; lowerSelN = 0; outEnN = 0; wrEnN = 0;
      #1 chk("R2 deselected laneOe", 32'(laneOe), 32'd0);
      chk("R2 deselected rdData", 32'(rdData), 32'd0);
      @(negedge clk); idle();
      doRead(17'd5, 2'b11, "R2 no write when deselected");
    end

    // R3: both lane selects high
    @(negedge clk);
    addr = 17'd6; wrData = 16'h4321; chipEnN = 0; chipEn = 1;
    upperSelN = 1; lowerSelN = 1; outEnN = 0; wrEnN = 0;
    #1 chk("R3 no lanes laneOe", 32'(laneOe), 32'd0);
    @(negedge clk); wrEnN = 1;
    #1 chk("R3 no lanes read laneOe", 32'(laneOe), 32'd0);
    @(negedge clk); idle();
    doRead(17'd6, 2'b11, "R3 no write without lanes");

    // R4: output disabled
    @(negedge clk);
    addr = 17'd7; chipEnN = 0; chipEn = 1; wrEnN = 1; outEnN = 1; upperSelN = 0; lowerSelN = 0;
    #1 chk("R4 output disabled laneOe", 32'(laneOe), 32'd0);
    chk("R4 output disabled rdData", 32'(rdData), 32'd0);

    // R10: reset during overlap drops the write, keeps memory
    @(negedge clk);
    addr = 17'd9; wrData = 16'hDEAD; chipEnN = 0; chipEn = 1;
    upperSelN = 0; lowerSelN = 0; outEnN = 1; wrEnN = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk); wrEnN = 1;
    @(negedge clk); rst_n = 1; idle();
    doRead(17'd9, 2'b11, "R10 reset drops pending write");
    doRead(17'd10, 2'b11, "R10 memory survives reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule